// File: doc/BRIEF.md
# Cartesian Port Format Stage

This block sits between the external data pins and an iterative coordinate-rotation core. It handles the number formats on the Cartesian side. A format select picks two's complement (high) or sign-and-magnitude (low), where a set top bit negates the value. In rectangular-to-polar mode the block turns incoming x and y words into a 17-bit two's complement internal form for the core. In polar-to-rectangular mode it passes the radius and the phase in unsigned form.

On the way out, the block handles results from the core. In polar-to-rectangular mode it encodes the rotated x and y results in the selected format. A result the 16-bit port cannot represent is clamped, and a registered overflow flag is raised. In rectangular-to-polar mode the magnitude and phase words pass straight through and no overflow is flagged. Each of the two output registers drives its port only while its active-low enable is low. The core and any phase accumulation lie outside this block.

Top module: `cart_port_stage`

## Requirements
- R1: Each internal input register (x and y) loads on a rising clock edge when its load strobe is high and otherwise keeps its value.
- R2: In rectangular-to-polar mode with two's complement selected (format select = 1), the loaded 16-bit word is sign-extended to the 17-bit internal value.
- R3: In rectangular-to-polar mode with sign-and-magnitude selected (format select = 0), bit 15 set negates the 15-bit magnitude in bits 14..0. The word 16'h8000 (negative zero) loads as internal zero.
- R4: In polar-to-rectangular mode, both input words are loaded zero-extended as unsigned values, whatever the format select.
- R5: In polar-to-rectangular mode with two's complement selected, a result in -32768..32767 is output as its 16-bit two's complement code, and -32768 (16'h8000) does not raise overflow.
- R6: In polar-to-rectangular mode with sign-and-magnitude selected, a result in -32767..32767 is output as sign bit 15 plus magnitude in bits 14..0, with zero as 16'h0000. Both +32768 and -32768 overflow.
- R7: An out-of-range component saturates. A positive one gives 16'h7FFF. A negative one gives 16'h8000 in two's complement and 16'hFFFF in sign-and-magnitude.
- R8: The overflow flag is registered together with the outputs. It is high in the cycle after either component is out of range, and low again in the cycle after both are in range.
- R9: In rectangular-to-polar mode, the low 16 bits of the magnitude and phase results pass unchanged to the x and y output registers, and overflow stays low.
- R10: Each output port is driven from its register while its active-low enable is 0 and is high impedance while it is 1.
- R11: Synchronous active-high reset clears the input registers, the output registers and the overflow flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| fmt_tc | input | 1 | 1 = two's complement, 0 = sign-and-magnitude |
| r2p_mode | input | 1 | 1 = rectangular-to-polar, 0 = polar-to-rectangular |
| ld_x | input | 1 | Load strobe for the x/radius input register |
| ld_y | input | 1 | Load strobe for the y/phase input register |
| x_pin | input | 16 | x coordinate or radius input word |
| y_pin | input | 16 | y coordinate or phase input word |
| core_x | output | 17 | Internal x/radius value to the core |
| core_y | output | 17 | Internal y/phase value to the core |
| res_x | input | 18 | Core result: signed rotated x, or magnitude in low bits |
| res_y | input | 18 | Core result: signed rotated y, or phase in low bits |
| oe_x_n | input | 1 | Active-low output enable for x_out |
| oe_y_n | input | 1 | Active-low output enable for y_out |
| x_out | output | 16 | Registered x / magnitude output, tri-stated |
| y_out | output | 16 | Registered y / phase output, tri-stated |
| ovf | output | 1 | Registered overflow flag |

## Verification
The hardest cases to reach are the ones exactly at the asymmetric edge of the range. A result of -32768 is legal in one format and an overflow in the other, and +32768 overflows in both. The bench drives the core-result ports directly with these values and with neighbours one step inside the range. It does this in both formats, so it can sample the flag rising and then falling in consecutive cycles. The bench also applies the negative-zero input word in sign-and-magnitude mode. To observe high impedance, the bench pulls the output nets up, so an undriven port reads as all ones while the register holds a different pattern.

// File: rtl/cps_pkg.sv
package cps_pkg;
  typedef enum logic {FMT_SM = 1'b0, FMT_TC = 1'b1} fmt_e;
  localparam int AXES = 2;
endpackage

// File: rtl/cps_in_stage.sv
module cps_in_stage #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld,
  input  logic         tc,
  input  logic         r2p,
  input  logic [W-1:0] pin,
  output logic [W:0]   q
);
  logic [W:0] mag;
  logic [W:0] nxt;

  always_comb begin
    mag = {2'b00, pin[W-2:0]};
    if (!r2p)
      nxt = {1'b0, pin};
    else if (tc == cps_pkg::FMT_TC)
      nxt = {pin[W-1], pin};
    else if (pin[W-1])
      nxt = (W+1)'(0) - mag;
    else
      nxt = mag;
  end

  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (ld) q <= nxt;
  end
endmodule

// File: rtl/cps_out_stage.sv
module cps_out_stage #(
  parameter int W  = 16,
  parameter int RW = W + 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tc,
  input  logic                 r2p,
  input  logic signed [RW-1:0] res,
  output logic [W-1:0]         q,
  output logic                 ovr
);
  localparam logic signed [RW-1:0] POS_LIM = RW'((1 << (W-1)) - 1);
  localparam logic signed [RW-1:0] TC_NEG  = -POS_LIM - RW'(1);
  localparam logic signed [RW-1:0] SM_NEG  = -POS_LIM;

  logic signed [RW-1:0] neg_lim;
  logic signed [RW-1:0] absv;
  logic [W-1:0]         nxt;

  always_comb begin
    neg_lim = tc ? TC_NEG : SM_NEG;
    absv    = -res;
    ovr     = 1'b0;
    if (r2p) begin
      nxt = res[W-1:0];
    end else if (res > POS_LIM) begin
      nxt = {1'b0, {(W-1){1'b1}}};
      ovr = 1'b1;
    end else if (res < neg_lim) begin
      nxt = tc ? {1'b1, {(W-1){1'b0}}} : {W{1'b1}};
      ovr = 1'b1;
    end else if (tc) begin
      nxt = res[W-1:0];
    end else if (res < 0) begin
      nxt = {1'b1, absv[W-2:0]};
    end else begin
      nxt = {1'b0, res[W-2:0]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= nxt;
  end
endmodule

// File: rtl/cart_port_stage.sv
module cart_port_stage #(
  parameter int W  = 16,
  parameter int RW = W + 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fmt_tc,
  input  logic          r2p_mode,
  input  logic          ld_x,
  input  logic          ld_y,
  input  logic [W-1:0]  x_pin,
  input  logic [W-1:0]  y_pin,
  output logic [W:0]    core_x,
  output logic [W:0]    core_y,
  input  logic [RW-1:0] res_x,
  input  logic [RW-1:0] res_y,
  input  logic          oe_x_n,
  input  logic          oe_y_n,
  output logic [W-1:0]  x_out,
  output logic [W-1:0]  y_out,
  output logic          ovf
);
  import cps_pkg::*;

  logic [AXES-1:0]          ld_v;
  logic [AXES-1:0][W-1:0]   pin_v;
  logic [AXES-1:0][W:0]     core_v;
  logic [AXES-1:0][RW-1:0]  res_v;
  logic [AXES-1:0][W-1:0]   out_q;
  logic [AXES-1:0]          ovr_v;

  assign ld_v  = {ld_y, ld_x};
  assign pin_v = {y_pin, x_pin};
  assign res_v = {res_y, res_x};

  for (genvar a = 0; a < AXES; a++) begin : g_axis
    cps_in_stage #(.W(W)) u_in (
      .clk (clk), .rst (rst), .ld (ld_v[a]), .tc (fmt_tc),
      .r2p (r2p_mode), .pin (pin_v[a]), .q (core_v[a])
    );
    cps_out_stage #(.W(W), .RW(RW)) u_out (
      .clk (clk), .rst (rst), .tc (fmt_tc), .r2p (r2p_mode),
      .res ($signed(res_v[a])), .q (out_q[a]), .ovr (ovr_v[a])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) ovf <= 1'b0;
    else     ovf <= |ovr_v;
  end

  assign core_x = core_v[0];
  assign core_y = core_v[1];
  assign x_out  = oe_x_n ? 'z : out_q[0];
  assign y_out  = oe_y_n ? 'z : out_q[1];
endmodule

// File: rtl/cps_checker.sv
module cps_checker #(
  parameter int W  = 16,
  parameter int RW = W + 2
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   fmt_tc,
  input logic                   r2p_mode,
  input logic                   ld_x,
  input logic [W-1:0]           x_pin,
  input logic [W:0]             core_x,
  input logic [RW-1:0]          res_x,
  input logic [1:0][W-1:0]      out_q,
  input logic                   ovf
);
  localparam logic signed [RW-1:0] POS_LIM = RW'((1 << (W-1)) - 1);

  a_r1_hold: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(ld_x)) |-> $stable(core_x));

  a_r3_neg_zero_in: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(ld_x && r2p_mode && !fmt_tc && x_pin[W-2:0] == '0))
      |-> core_x == '0);

  a_r9_no_overflow: assert property (@(posedge clk) disable iff (rst)
    $past(r2p_mode) |-> !ovf);

  a_r6_no_neg_zero_out: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(r2p_mode) && !$past(fmt_tc))
      |-> (out_q[0] != {1'b1, {(W-1){1'b0}}} && out_q[1] != {1'b1, {(W-1){1'b0}}}));

  a_r7_saturated: assert property (@(posedge clk) disable iff (rst)
    ovf |-> (out_q[0][W-2:0] == '1 || out_q[1][W-2:0] == '1 ||
             out_q[0] == {1'b1, {(W-1){1'b0}}} || out_q[1] == {1'b1, {(W-1){1'b0}}}));

  a_r8_ovf_rise: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(r2p_mode) && $past($signed(res_x) > POS_LIM)) |-> ovf);
endmodule

bind cart_port_stage cps_checker #(.W(W), .RW(RW)) u_chk (
  .clk (clk), .rst (rst), .fmt_tc (fmt_tc), .r2p_mode (r2p_mode),
  .ld_x (ld_x), .x_pin (x_pin), .core_x (core_x), .res_x (res_x),
  .out_q (out_q), .ovf (ovf)
);

// File: tb/tb_cart_port_stage.sv
module tb_cart_port_stage;
  logic        clk = 1'b0;
  logic        rst, fmt_tc, r2p_mode, ld_x, ld_y, oe_x_n, oe_y_n;
  logic [15:0] x_pin, y_pin;
  logic [17:0] res_x, res_y;
  logic [16:0] core_x, core_y;
  wire  [15:0] x_bus, y_bus;
  logic        ovf;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  for (genvar i = 0; i < 16; i++) begin : g_pu
    pullup (x_bus[i]);
    pullup (y_bus[i]);
  end

  cart_port_stage dut (
    .clk (clk), .rst (rst), .fmt_tc (fmt_tc), .r2p_mode (r2p_mode),
    .ld_x (ld_x), .ld_y (ld_y), .x_pin (x_pin), .y_pin (y_pin),
    .core_x (core_x), .core_y (core_y), .res_x (res_x), .res_y (res_y),
    .oe_x_n (oe_x_n), .oe_y_n (oe_y_n), .x_out (x_bus), .y_out (y_bus),
    .ovf (ovf)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load(input logic tc, input logic r2p, input logic [15:0] xv, input logic [15:0] yv);
    @(negedge clk);
    fmt_tc = tc; r2p_mode = r2p; x_pin = xv; y_pin = yv; ld_x = 1'b1; ld_y = 1'b1;
    @(negedge clk);
    ld_x = 1'b0; ld_y = 1'b0;
  endtask

  task automatic result(input logic tc, input logic r2p, input logic [17:0] xv, input logic [17:0] yv);
    @(negedge clk);
    fmt_tc = tc; r2p_mode = r2p; res_x = xv; res_y = yv;
    @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R11 core_x", 32'(core_x), 32'h0);
    chk("R11 core_y", 32'(core_y), 32'h0);
    chk("R11 ovf", 32'(ovf), 32'h0);
    chk("R11 x_out", 32'(x_bus), 32'h0);
  endtask

  task automatic t_inputs();
    load(1'b1, 1'b1, 16'hFFFE, 16'h8000);
    chk("R2 tc -2", 32'(core_x), 32'h1FFFE);
    chk("R2 tc -32768", 32'(core_y), 32'h18000);
    load(1'b0, 1'b1, 16'h8005, 16'h0005);
    chk("R3 sm -5", 32'(core_x), 32'h1FFFB);
    chk("R3 sm +5", 32'(core_y), 32'h00005);
    load(1'b0, 1'b1, 16'h8000, 16'hFFFF);
    chk("R3 negative zero", 32'(core_x), 32'h0);
    chk("R3 sm -32767", 32'(core_y), 32'h18001);
    load(1'b1, 1'b0, 16'hB505, 16'hC000);
    chk("R4 radius", 32'(core_x), 32'h0B505);
    chk("R4 phase", 32'(core_y), 32'h0C000);
    @(negedge clk);
    x_pin = 16'h1234; y_pin = 16'h4321;
    @(negedge clk);
    chk("R1 hold x", 32'(core_x), 32'h0B505);
    chk("R1 hold y", 32'(core_y), 32'h0C000);
  endtask

  task automatic t_outputs();
    result(1'b1, 1'b0, 18'h38000, 18'h07FFF);
    chk("R5 tc -32768", 32'(x_bus), 32'h8000);
    chk("R5 tc 32767", 32'(y_bus), 32'h7FFF);
    chk("R5 no ovf", 32'(ovf), 32'h0);
    result(1'b0, 1'b0, 18'h38000, 18'h3FFFB);
    chk("R7 sm neg sat", 32'(x_bus), 32'hFFFF);
    chk("R6 sm -5", 32'(y_bus), 32'h8005);
    chk("R6 sm -32768 ovf", 32'(ovf), 32'h1);
    result(1'b0, 1'b0, 18'h38001, 18'h00000);
    chk("R6 sm -32767", 32'(x_bus), 32'hFFFF);
    chk("R6 sm zero", 32'(y_bus), 32'h0000);
    chk("R8 ovf falls", 32'(ovf), 32'h0);
    result(1'b1, 1'b0, 18'h08000, 18'h37000);
    chk("R7 tc pos sat", 32'(x_bus), 32'h7FFF);
    chk("R7 tc neg sat", 32'(y_bus), 32'h8000);
    chk("R8 ovf rises", 32'(ovf), 32'h1);
    result(1'b1, 1'b0, 18'h00010, 18'h3FFF0);
    chk("R8 ovf clears", 32'(ovf), 32'h0);
    chk("R5 tc -16", 32'(y_bus), 32'hFFF0);
  endtask

  task automatic t_r2p_pass();
    result(1'b0, 1'b1, 18'h0B505, 18'h3C123);
    chk("R9 magnitude", 32'(x_bus), 32'hB505);
    chk("R9 phase", 32'(y_bus), 32'hC123);
    chk("R9 ovf low", 32'(ovf), 32'h0);
  endtask

  task automatic t_oe();
    result(1'b1, 1'b0, 18'h01234, 18'h00042);
    oe_x_n = 1'b1;
    #1;
    chk("R10 x hi-z", 32'(x_bus), 32'hFFFF);
    chk("R10 y driven", 32'(y_bus), 32'h0042);
    oe_x_n = 1'b0; oe_y_n = 1'b1;
    #1;
    chk("R10 x driven", 32'(x_bus), 32'h1234);
    chk("R10 y hi-z", 32'(y_bus), 32'hFFFF);
    oe_y_n = 1'b0;
  endtask

  initial begin
    rst = 1'b1; fmt_tc = 1'b1; r2p_mode = 1'b1; ld_x = 1'b0; ld_y = 1'b0;
    oe_x_n = 1'b0; oe_y_n = 1'b0; x_pin = '0; y_pin = '0; res_x = '0; res_y = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_inputs();
    t_outputs();
    t_r2p_pass();
    t_oe();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule